// File: doc/BRIEF.md
# Segmented Pipelined Ternary Prefix Matcher

This block holds a table of ternary prefixes, each as wide as the search key, and finds every entry that matches a key. The key and every stored prefix are cut into equal segments. Each segment is handled by its own pipeline stage, the most significant segment first. An entry is compared in a stage only while it is still live. It stays live while every earlier segment has matched and its prefix has not yet ended. A prefix ends in the first segment whose lowest bit is a don't-care. Because the prefix bits run from the top of the key downwards, no later bit can then be significant. Past that segment the entry is dropped from the search.

When a prefix ends inside a matching segment, the stage of that segment gives a coarse length. A prefix that ends in a later stage is always longer than one that ends earlier. The result therefore names the deepest stage in which any matching prefix ends, and the set of matching entries that end there. A later step resolves the exact longest match among those candidates. The table needs no length-sorted order, so a prefix of any length can be written into any free slot with a single write.

A new key may be presented on every cycle. Each result comes out after a fixed latency and carries its own valid strobe.

Top module: `seg_prefix_matcher`

## Requirements
- R1: A key presented with `srch_valid` high gives its result with `res_valid` high exactly 4 clock edges later. Keys may be presented on consecutive cycles, and each one gives its own result in the same order.
- R2: Each stored bit has a care flag. A bit with care 1 must equal the key bit. A bit with care 0 is a don't-care, and it is stored as value 0 with care 0. Stage 1 compares key bits [127:96], stage 2 bits [95:64], stage 3 bits [63:32] and stage 4 bits [31:0].
- R3: An entry is compared in a stage only when every earlier stage of the same key matched for it. A mismatch removes the entry from the result, whatever its later segments hold.
- R4: A prefix ends in the first stage k whose segment has care 0 at its lowest bit (bit 128-32k). Bits in later segments are never compared for that entry. An entry with no such segment ends in stage 4.
- R5: `res_stage` is the deepest stage (1 to 4) in which a matching entry ends, or 0 when no entry matches.
- R6: `res_cand` has bit i set exactly when entry i matches and ends in stage `res_stage`.
- R7: `res_match` has bit i set exactly when entry i matches: it is valid, and every segment up to its ending stage matches. `res_any` is the OR of `res_match`.
- R8: An entry whose valid flag is 0 never matches. A write with `wr_vld` 0 removes an entry.
- R9: An entry with every care bit 0 (a zero-length prefix) matches every key and ends in stage 1.
- R10: A write goes to any index, whatever the length of the prefix. It is seen by a key presented in the cycle after the write cycle.
- R11: After reset, `res_valid` is 0 and the table holds no valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | $clog2(ENTRIES) | Entry index to write |
| wr_vld | input | 1 | Valid flag written to the entry |
| wr_value | input | 128 | Prefix value bits |
| wr_care | input | 128 | Per-bit care flags (0 = don't-care) |
| srch_valid | input | 1 | Key strobe |
| srch_key | input | 128 | Search key |
| res_valid | output | 1 | Result strobe |
| res_match | output | ENTRIES | Matching entries |
| res_stage | output | 3 | Deepest ending stage of a match, 0 if none |
| res_cand | output | ENTRIES | Matching entries ending in `res_stage` |
| res_any | output | 1 | At least one entry matched |

## Verification
Each stage compares against the table as it stands when the key reaches that stage. The assertions that relate the match, candidate and stage fields therefore assume the table does not change while a key is in flight. The bench keeps to this. It writes only while the pipeline is idle, except in the write-then-search case of R10, where the key enters the pipeline one cycle after the write. The bench sweeps a single-bit flip of a base key across all 128 positions, against nested prefixes of many lengths. It also runs random tables that include care patterns which are not contiguous.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int DEF_ENTRIES = 16;
    localparam int DEF_SEG_W   = 32;
    localparam int DEF_SEGS    = 4;

    // Width of a stage number that also encodes "none" as 0.
    function automatic int stage_code_w(input int segs);
        return $clog2(segs + 1);
    endfunction
endpackage

// File: rtl/prefix_table.sv
module prefix_table #(
    parameter int ENTRIES = lpm_pkg::DEF_ENTRIES,
    parameter int KEY_W   = lpm_pkg::DEF_SEG_W * lpm_pkg::DEF_SEGS,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     wr_vld,
    input  logic [KEY_W-1:0]         wr_value,
    input  logic [KEY_W-1:0]         wr_care,
    output logic [ENTRIES*KEY_W-1:0] tbl_value,
    output logic [ENTRIES*KEY_W-1:0] tbl_care,
    output logic [ENTRIES-1:0]       tbl_vld
);
    typedef struct packed {
        logic [ENTRIES-1:0]       vld;
        logic [ENTRIES*KEY_W-1:0] value;
        logic [ENTRIES*KEY_W-1:0] care;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            st_d.vld[wr_idx] = wr_vld;
            // don't-care cells hold value 0 and care 0
            st_d.value[32'(wr_idx)*KEY_W +: KEY_W] = wr_value & wr_care;
            st_d.care[32'(wr_idx)*KEY_W +: KEY_W]  = wr_care;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl_value = st_q.value;
    assign tbl_care  = st_q.care;
    assign tbl_vld   = st_q.vld;

    // R10: a write lands at the addressed slot on the next edge
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) < ENTRIES)) |=> (tbl_vld[$past(wr_idx)] == $past(wr_vld)));

    // R2: stored don't-care cells never carry a 1 in the value plane
    a_r2_dc_cells_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_value & ~tbl_care) == '0);
endmodule

// File: rtl/seg_compare.sv
module seg_compare #(
    parameter int ENTRIES = lpm_pkg::DEF_ENTRIES,
    parameter int SEG_W   = lpm_pkg::DEF_SEG_W
) (
    input  logic [SEG_W-1:0]         key_seg,
    input  logic [ENTRIES*SEG_W-1:0] seg_value,
    input  logic [ENTRIES*SEG_W-1:0] seg_care,
    output logic [ENTRIES-1:0]       hit,
    output logic [ENTRIES-1:0]       tail_free
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [SEG_W-1:0] v, c;
        assign v = seg_value[e*SEG_W +: SEG_W];
        assign c = seg_care[e*SEG_W +: SEG_W];
        assign hit[e]       = (((key_seg ^ v) & c) == '0);
        // lowest bit of the slice is the last bit of the segment
        assign tail_free[e] = ~c[0];
    end
endmodule

// File: rtl/lpm_stage.sv
module lpm_stage #(
    parameter int ENTRIES  = lpm_pkg::DEF_ENTRIES,
    parameter int SEG_W    = lpm_pkg::DEF_SEG_W,
    parameter int SEGS     = lpm_pkg::DEF_SEGS,
    parameter int STAGE_NO = 1,
    localparam int KEY_W   = SEG_W * SEGS,
    localparam int STG_W   = lpm_pkg::stage_code_w(SEGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [KEY_W-1:0]         in_key,
    input  logic [ENTRIES-1:0]       in_live,
    input  logic [ENTRIES-1:0]       in_match,
    input  logic [STG_W-1:0]         in_stage,
    input  logic [ENTRIES-1:0]       in_cand,
    input  logic [ENTRIES*KEY_W-1:0] tbl_value,
    input  logic [ENTRIES*KEY_W-1:0] tbl_care,
    output logic                     out_valid,
    output logic [KEY_W-1:0]         out_key,
    output logic [ENTRIES-1:0]       out_live,
    output logic [ENTRIES-1:0]       out_match,
    output logic [STG_W-1:0]         out_stage,
    output logic [ENTRIES-1:0]       out_cand
);
    localparam int SEG_LO  = (SEGS - STAGE_NO) * SEG_W;
    localparam bit IS_LAST = (STAGE_NO == SEGS);

    typedef struct packed {
        logic               valid;
        logic [KEY_W-1:0]   key;
        logic [ENTRIES-1:0] live;
        logic [ENTRIES-1:0] match;
        logic [STG_W-1:0]   stage;
        logic [ENTRIES-1:0] cand;
    } pipe_t;

    pipe_t p_d, p_q;

    logic [ENTRIES*SEG_W-1:0] seg_value, seg_care;
    logic [ENTRIES-1:0]       hit, tail_free, ends, cont;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slice
        assign seg_value[e*SEG_W +: SEG_W] = tbl_value[e*KEY_W + SEG_LO +: SEG_W];
        assign seg_care[e*SEG_W +: SEG_W]  = tbl_care[e*KEY_W + SEG_LO +: SEG_W];
    end

    seg_compare #(.ENTRIES(ENTRIES), .SEG_W(SEG_W)) u_cmp (
        .key_seg   (in_key[SEG_LO +: SEG_W]),
        .seg_value (seg_value),
        .seg_care  (seg_care),
        .hit       (hit),
        .tail_free (tail_free)
    );

    if (IS_LAST) begin : g_last
        // every surviving hit ends in the final segment
        assign ends = in_live & hit;
        assign cont = '0;
    end else begin : g_mid
        assign ends = in_live & hit & tail_free;
        assign cont = in_live & hit & ~tail_free;
    end

    always_comb begin
        p_d = '0;
        if (in_valid) begin
            p_d.valid = 1'b1;
            p_d.key   = in_key;
            p_d.live  = cont;
            p_d.match = in_match | ends;
            if (|ends) begin
                p_d.stage = STG_W'(STAGE_NO);
                p_d.cand  = ends;
            end else begin
                p_d.stage = in_stage;
                p_d.cand  = in_cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_valid = p_q.valid;
    assign out_key   = p_q.key;
    assign out_live  = p_q.live;
    assign out_match = p_q.match;
    assign out_stage = p_q.stage;
    assign out_cand  = p_q.cand;

    // R3: an entry can only stay live if it was live entering this stage
    a_r3_live_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_live & ~$past(in_live)) == '0));

    // R4: an entry that ended here is no longer searched
    a_r4_ended_not_live: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_live & out_match & ~$past(in_match)) == '0));

    // R5: the recorded ending stage never moves back
    a_r5_stage_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_stage >= $past(in_stage)));

    // R6: candidates are always matches
    a_r6_cand_in_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_cand & ~out_match) == '0));
endmodule

// File: rtl/seg_prefix_matcher.sv
module seg_prefix_matcher #(
    parameter int ENTRIES = lpm_pkg::DEF_ENTRIES,
    parameter int SEG_W   = lpm_pkg::DEF_SEG_W,
    parameter int SEGS    = lpm_pkg::DEF_SEGS,
    localparam int KEY_W  = SEG_W * SEGS,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int STG_W  = lpm_pkg::stage_code_w(SEGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_vld,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_care,
    input  logic               srch_valid,
    input  logic [KEY_W-1:0]   srch_key,
    output logic               res_valid,
    output logic [ENTRIES-1:0] res_match,
    output logic [STG_W-1:0]   res_stage,
    output logic [ENTRIES-1:0] res_cand,
    output logic               res_any
);
    logic [ENTRIES*KEY_W-1:0] tbl_value, tbl_care;
    logic [ENTRIES-1:0]       tbl_vld;

    prefix_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vld    (wr_vld),
        .wr_value  (wr_value),
        .wr_care   (wr_care),
        .tbl_value (tbl_value),
        .tbl_care  (tbl_care),
        .tbl_vld   (tbl_vld)
    );

    logic               pv    [SEGS+1];
    logic [KEY_W-1:0]   pkey  [SEGS+1];
    logic [ENTRIES-1:0] plive [SEGS+1];
    logic [ENTRIES-1:0] pmatch[SEGS+1];
    logic [STG_W-1:0]   pstage[SEGS+1];
    logic [ENTRIES-1:0] pcand [SEGS+1];

    assign pv[0]     = srch_valid;
    assign pkey[0]   = srch_key;
    assign plive[0]  = tbl_vld;
    assign pmatch[0] = '0;
    assign pstage[0] = '0;
    assign pcand[0]  = '0;

    for (genvar s = 0; s < SEGS; s++) begin : g_stage
        lpm_stage #(
            .ENTRIES(ENTRIES), .SEG_W(SEG_W), .SEGS(SEGS), .STAGE_NO(s + 1)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (pv[s]),
            .in_key    (pkey[s]),
            .in_live   (plive[s]),
            .in_match  (pmatch[s]),
            .in_stage  (pstage[s]),
            .in_cand   (pcand[s]),
            .tbl_value (tbl_value),
            .tbl_care  (tbl_care),
            .out_valid (pv[s+1]),
            .out_key   (pkey[s+1]),
            .out_live  (plive[s+1]),
            .out_match (pmatch[s+1]),
            .out_stage (pstage[s+1]),
            .out_cand  (pcand[s+1])
        );
    end

    assign res_valid = pv[SEGS];
    assign res_match = pmatch[SEGS];
    assign res_stage = pstage[SEGS];
    assign res_cand  = pcand[SEGS];
    assign res_any   = |pmatch[SEGS];

    // R7: a reported match always has an ending stage
    a_r7_any_has_stage: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_any == (res_stage != '0)));

    // R5: a nonzero stage always names at least one candidate
    a_r5_stage_has_cand: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_stage != '0) == (res_cand != '0)));

    // R1: result fields stay clear between strobes
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_match == '0 && res_cand == '0 && res_stage == '0));

    // R1: no result leaves the pipe without a matching strobe four edges back
    a_r1_valid_from_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(pv[SEGS-1]));
endmodule

// File: tb/seg_prefix_matcher_bench.sv
module seg_prefix_matcher_bench;
    localparam int N  = 8;
    localparam int SW = 32;
    localparam int NS = 4;
    localparam int KW = SW * NS;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_vld = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_value = '0, wr_care = '0;
    logic srch_valid = 1'b0;
    logic [KW-1:0] srch_key = '0;
    logic res_valid, res_any;
    logic [N-1:0] res_match, res_cand;
    logic [2:0] res_stage;

    seg_prefix_matcher #(.ENTRIES(N), .SEG_W(SW), .SEGS(NS)) u_seg_prefix_matcher (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
        .wr_value(wr_value), .wr_care(wr_care), .srch_valid(srch_valid),
        .srch_key(srch_key), .res_valid(res_valid), .res_match(res_match),
        .res_stage(res_stage), .res_cand(res_cand), .res_any(res_any)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // mirror of the table
    logic [KW-1:0] m_val [N];
    logic [KW-1:0] m_care[N];
    logic          m_vld [N];

    function automatic void model(input logic [KW-1:0] k, output logic [N-1:0] mt,
                                  output logic [2:0] st, output logic [N-1:0] cd);
        int endst[N];
        mt = '0; st = '0; cd = '0;
        for (int e = 0; e < N; e++) begin
            endst[e] = 0;
            if (m_vld[e]) begin
                for (int s = 0; s < NS; s++) begin
                    int lo = (NS - 1 - s) * SW;
                    logic [SW-1:0] kv = k[lo +: SW];
                    logic [SW-1:0] vv = m_val[e][lo +: SW];
                    logic [SW-1:0] cv = m_care[e][lo +: SW];
                    if (((kv ^ vv) & cv) != '0) break;
                    if (s == NS - 1 || cv[0] == 1'b0) begin
                        endst[e] = s + 1;
                        break;
                    end
                end
            end
            if (endst[e] != 0) begin
                mt[e] = 1'b1;
                if (endst[e] > int'(st)) st = 3'(endst[e]);
            end
        end
        for (int e = 0; e < N; e++) if (endst[e] != 0 && endst[e] == int'(st)) cd[e] = 1'b1;
    endfunction

    function automatic logic [KW-1:0] pfx_care(input int len);
        logic [KW-1:0] c = '0;
        for (int i = 0; i < len; i++) c[KW-1-i] = 1'b1;
        return c;
    endfunction

    function automatic logic [KW-1:0] rnd_key();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // expected-result queue
    logic [N-1:0] q_match[4096];
    logic [N-1:0] q_cand [4096];
    logic [2:0]   q_stage[4096];
    int           q_cyc  [4096];
    int wp = 0, rp = 0;
    logic [N-1:0] last_match, last_cand;
    logic [2:0]   last_stage;
    logic         last_any;

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (rp == wp) begin
                chk("R1 result without key", 1, 0);
            end else begin
                chk("R1 latency", 128'(cyc - q_cyc[rp]), 128'(4));
                chk("R7 match vector", 128'(res_match), 128'(q_match[rp]));
                chk("R5 ending stage", 128'(res_stage), 128'(q_stage[rp]));
                chk("R6 candidates", 128'(res_cand), 128'(q_cand[rp]));
                chk("R7 any flag", 128'(res_any), 128'(q_match[rp] != '0));
                rp++;
            end
            last_match = res_match; last_cand = res_cand;
            last_stage = res_stage; last_any = res_any;
        end
    end

    task automatic record(input logic [KW-1:0] k);
        logic [N-1:0] mt, cd;
        logic [2:0] st;
        model(k, mt, st, cd);
        q_match[wp] = mt; q_cand[wp] = cd; q_stage[wp] = st; q_cyc[wp] = cyc;
        wp++;
    endtask

    task automatic issue(input logic [KW-1:0] k);
        @(negedge clk);
        srch_valid = 1'b1; srch_key = k;
        record(k);
    endtask

    task automatic drain();
        @(negedge clk);
        srch_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1 every key answered", 128'(rp), 128'(wp));
    endtask

    task automatic put(input int idx, input logic v, input logic [KW-1:0] val, input logic [KW-1:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_vld = v; wr_value = val; wr_care = c;
        m_vld[idx] = v; m_val[idx] = val & c; m_care[idx] = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic search_one(input logic [KW-1:0] k);
        issue(k);
        drain();
    endtask

    task automatic expect_last(input string tag, input logic [N-1:0] mt,
                               input logic [2:0] st, input logic [N-1:0] cd);
        chk({tag, " match"}, 128'(last_match), 128'(mt));
        chk({tag, " stage"}, 128'(last_stage), 128'(st));
        chk({tag, " cand"},  128'(last_cand),  128'(cd));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [KW-1:0] base, k2;
        int lens[N];
        for (int e = 0; e < N; e++) begin m_vld[e] = 0; m_val[e] = '0; m_care[e] = '0; end
        repeat (3) @(negedge clk);
        chk("R11 no result in reset", 128'(res_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 no result after reset", 128'(res_valid), 128'(0));

        base = rnd_key();
        // R11/R8: empty table matches nothing
        search_one(base);
        expect_last("R11 empty table", '0, 3'd0, '0);
        chk("R8 empty any", 128'(last_any), 128'(0));

        // R9: zero-length prefix at entry 3
        put(3, 1'b1, rnd_key(), '0);
        search_one(base);
        expect_last("R9 zero-length", 8'h08, 3'd1, 8'h08);
        search_one(~base);
        expect_last("R9 zero-length other key", 8'h08, 3'd1, 8'h08);

        // R5/R6: length-40 prefix ends in stage 2
        put(5, 1'b1, base, pfx_care(40));
        search_one(base);
        expect_last("R5 deeper stage wins", 8'h28, 3'd2, 8'h20);

        // R2: flip a cared bit in segment 1
        search_one(base ^ (128'(1) << (127 - 10)));
        expect_last("R2 cared bit mismatch", 8'h08, 3'd1, 8'h08);
        // R4: bits past the prefix are not compared
        search_one(base ^ (128'(1) << (127 - 45)));
        expect_last("R4 bit beyond prefix", 8'h28, 3'd2, 8'h20);

        // R3: full-care entry mismatching in segment 2 drops out
        put(1, 1'b1, base ^ (128'(1) << (127 - 40)), '1);
        // R4: entry ending in stage 1 with cared but differing bits later
        k2 = pfx_care(128);
        k2[96] = 1'b0;
        put(2, 1'b1, base ^ (128'(1) << 5), k2);
        search_one(base);
        expect_last("R3R4 early end and late mismatch", 8'h2C, 3'd2, 8'h20);

        // R8: invalidate entry 5
        put(5, 1'b0, base, pfx_care(40));
        search_one(base);
        expect_last("R8 invalidated entry", 8'h0C, 3'd1, 8'h0C);

        // R10: write then search on the next cycle, full-length at entry 7
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(7); wr_vld = 1'b1; wr_value = base; wr_care = '1;
        m_vld[7] = 1; m_val[7] = base; m_care[7] = '1;
        @(negedge clk);
        wr_en = 1'b0;
        srch_valid = 1'b1; srch_key = base;
        record(base);
        drain();
        expect_last("R10 write seen next cycle", 8'h8C, 3'd4, 8'h80);

        // Sweep A: nested prefixes of many lengths, single-bit flips everywhere
        lens = '{0, 7, 31, 32, 50, 64, 100, 128};
        for (int e = 0; e < N; e++) put(e, 1'b1, base, pfx_care(lens[e]));
        issue(base);
        for (int p = 0; p < KW; p++) issue(base ^ (128'(1) << p));
        drain();

        // Sweep B: random tables with arbitrary care patterns, back-to-back keys
        for (int r = 0; r < 12; r++) begin
            for (int e = 0; e < N; e++) begin
                logic [KW-1:0] c;
                if (e % 3 == 0) c = rnd_key();
                else            c = pfx_care(int'($urandom % 129));
                put(e, ($urandom % 5) != 0, (e < 4) ? base : rnd_key(), c);
            end
            for (int j = 0; j < 40; j++) begin
                logic [KW-1:0] k = (j % 4 == 3) ? rnd_key() : m_val[$urandom % N];
                if (j % 2 == 1) k = k ^ (128'(1) << ($urandom % KW));
                issue(k);
            end
            drain();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule